// File: doc/BRIEF.md
# Read Request Scheduler with Age-Escalated Starvation Control

This block holds up to sixteen pending read requests, each tagged with a request id and the memory region it targets. Every cycle it offers one request to the command path. Normally the offer is the oldest queued request whose region is currently allowed to take another read. An external admission unit decides which regions are allowed and supplies that decision as a per-region bit vector. Regions far from the supply can accept fewer concurrent reads. A steady stream of reads to the well-supplied regions could therefore keep a request to a poorly supplied region waiting indefinitely.

To bound that wait, the block keeps a running average of measured read latency. Any request that has waited longer than 1.2 times that average becomes urgent. The oldest urgent request takes absolute priority. While its region is not admitted, nothing else issues, so the active reads drain until the urgent request fits. The block also reports the urgent request's region on a reservation output, so the admission unit knows which region needs room.

Requests arrive on a valid/ready port. `enq_ready` depends only on occupancy: it is high whenever fewer than sixteen requests are held. A request enters on a cycle with `enq_valid` and `enq_ready` both high. The issue port is also valid/ready. The offer is recomputed every cycle from the queue, the admission vector and the urgency state, so `iss_valid` and the offered request may change while `iss_ready` is low. A request leaves the queue only on a cycle with `iss_valid` and `iss_ready` both high. Completions are a plain strobe carrying the measured latency.

Top module: `rd_starve_sched`

## Requirements
- R1: After reset the queue is empty, `enq_ready` is 1, `iss_valid` and `rsv_valid` are 0, and the latency average equals the parameter `AVG_INIT`.
- R2: `enq_ready` is 0 exactly when 16 requests are held. An `enq_valid` while `enq_ready` is 0 leaves the queue unchanged. An enqueue and an issue may happen in the same cycle.
- R3: When no request is urgent, the offer is the oldest queued request whose region bit in `region_ok` is 1. Bit n of `region_ok` belongs to region n. If no such request exists, `iss_valid` is 0.
- R4: A request is removed only on a cycle with `iss_valid` and `iss_ready` both high. The remaining requests keep their arrival order. A new request is placed behind all requests still held.
- R5: Each held request's age starts at 0 on the cycle after it enters and increases by one per cycle. The age saturates at 2^10-1 and does not wrap.
- R6: A request is urgent exactly when 5·age > 6·avg. Here avg is the 3-bit fixed-point average divided by 8, so the exact test is age·40 > avg_fx·6.
- R7: The fixed-point average avg_fx (8 × average) starts at 8·`AVG_INIT`. On each cycle with `cpl_valid` high it becomes avg_fx − floor(avg_fx/8) + `cpl_latency`. The new value governs urgency from the next cycle on.
- R8: While any request is urgent and the oldest urgent request's region is admitted, that request is offered with `iss_urgent` = 1.
- R9: While the oldest urgent request's region is not admitted, `iss_valid` is 0, whatever other requests are admissible.
- R10: `rsv_valid` is 1 exactly when some request is urgent, and `rsv_region` then gives the region of the oldest urgent request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | New request present |
| enq_ready | output | 1 | Queue can accept a request |
| enq_id | input | 4 | Id of the new request |
| enq_region | input | 3 | Target region of the new request |
| region_ok | input | 8 | Admission result, one bit per region, 1 = a read may issue there |
| iss_valid | output | 1 | A request is offered |
| iss_ready | input | 1 | Command path takes the offered request |
| iss_id | output | 4 | Id of the offered request |
| iss_region | output | 3 | Region of the offered request |
| iss_urgent | output | 1 | Offered request is urgent |
| rsv_valid | output | 1 | An urgent request is pending |
| rsv_region | output | 3 | Region the oldest urgent request needs admitted |
| cpl_valid | input | 1 | A read completed this cycle |
| cpl_latency | input | 10 | Measured latency of that read in cycles |

## Verification
An issue and an enqueue can fall in the same cycle. The queue must then close the gap left by the departing request and place the newcomer behind the survivors, so any slip shows up as a wrong id on a later offer. A completion can also arrive in the very cycle an entry's age crosses the old threshold, which tests that the new average applies only from the following cycle. Both cases are provoked by the continuous enqueue-and-drain traffic of the starvation phase and by a long stretch of random enqueues, ready levels, admission vectors and completions. A behavioural queue model predicts every output on every cycle and judges the results.

// File: rtl/rss_pkg.sv
package rss_pkg;
  parameter int RSS_ID_W     = 4;
  parameter int RSS_REGION_W = 3;
  parameter int RSS_AGE_W    = 10;

  typedef struct packed {
    logic                    vld;
    logic [RSS_ID_W-1:0]     id;
    logic [RSS_REGION_W-1:0] region;
    logic [RSS_AGE_W-1:0]    age;
  } rss_entry_t;
endpackage

// File: rtl/rss_lat_avg.sv
module rss_lat_avg #(
  parameter int LAT_W     = 10,
  parameter int EMA_SHIFT = 3,
  parameter int AVG_INIT  = 32,
  localparam int AVG_W    = LAT_W + EMA_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpl_valid,
  input  logic [LAT_W-1:0] cpl_latency,
  output logic [AVG_W-1:0] avg_fx
);
  // Average held scaled by 2^EMA_SHIFT so the fraction survives the shift.
  logic [AVG_W-1:0] avg_nxt;

  always_comb begin
    avg_nxt = avg_fx - (avg_fx >> EMA_SHIFT) + AVG_W'(cpl_latency);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         avg_fx <= AVG_W'(AVG_INIT << EMA_SHIFT);
    else if (cpl_valid) avg_fx <= avg_nxt;
  end
endmodule

// File: rtl/rss_queue.sv
module rss_queue
  import rss_pkg::*;
#(
  parameter int DEPTH   = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enq_fire,
  input  logic [RSS_ID_W-1:0]     enq_id,
  input  logic [RSS_REGION_W-1:0] enq_region,
  input  logic                    rm_fire,
  input  logic [IDX_W-1:0]        rm_idx,
  output rss_entry_t              ent [DEPTH],
  output logic [CNT_W-1:0]        cnt
);
  // Collapsing queue: slot 0 always holds the oldest request.
  rss_entry_t       up  [DEPTH];
  rss_entry_t       nxt [DEPTH];
  logic [CNT_W-1:0] cnt_after;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_up
      if (g < DEPTH - 1) begin : g_mid
        assign up[g] = ent[g+1];
      end else begin : g_top
        assign up[g] = '0;
      end
    end
  endgenerate

  always_comb begin
    cnt_after = cnt - CNT_W'(rm_fire);
    for (int i = 0; i < DEPTH; i++) begin
      if (rm_fire && (IDX_W'(i) >= rm_idx)) nxt[i] = up[i];
      else                                  nxt[i] = ent[i];
      if (nxt[i].vld && (nxt[i].age != '1)) nxt[i].age = nxt[i].age + 1'b1;
      if (enq_fire && (CNT_W'(i) == cnt_after)) begin
        nxt[i].vld    = 1'b1;
        nxt[i].id     = enq_id;
        nxt[i].region = enq_region;
        nxt[i].age    = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else begin
      cnt <= cnt_after + CNT_W'(enq_fire);
      for (int i = 0; i < DEPTH; i++) ent[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/rss_pick.sv
module rss_pick
  import rss_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int AVG_W     = 13,
  parameter int THR_NUM   = 6,
  parameter int THR_DEN   = 5,
  parameter int EMA_SHIFT = 3,
  localparam int NREG     = 1 << RSS_REGION_W,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CMP_W    = RSS_AGE_W + AVG_W + 8
) (
  input  rss_entry_t       ent [DEPTH],
  input  logic [AVG_W-1:0] avg_fx,
  input  logic [NREG-1:0]  region_ok,
  output logic             sel_vld,
  output logic [IDX_W-1:0] sel_idx,
  output logic             sel_urg,
  output logic             rsv_vld,
  output logic [IDX_W-1:0] rsv_idx
);
  logic [DEPTH-1:0] urg;
  logic [CMP_W-1:0] thr;
  logic             ok_vld;
  logic [IDX_W-1:0] ok_idx;

  // Threshold side of age*DEN*2^S > avg_fx*NUM, shared by all entries.
  assign thr = CMP_W'(avg_fx) * CMP_W'(THR_NUM);

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_urg
      logic [CMP_W-1:0] lhs;
      assign lhs    = (CMP_W'(ent[g].age) * CMP_W'(THR_DEN)) << EMA_SHIFT;
      assign urg[g] = ent[g].vld && (lhs > thr);
    end
  endgenerate

  always_comb begin
    rsv_vld = 1'b0;
    rsv_idx = '0;
    ok_vld  = 1'b0;
    ok_idx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (urg[i]) begin
        rsv_vld = 1'b1;
        rsv_idx = IDX_W'(i);
      end
      if (ent[i].vld && region_ok[ent[i].region]) begin
        ok_vld = 1'b1;
        ok_idx = IDX_W'(i);
      end
    end
    if (rsv_vld) begin
      sel_idx = rsv_idx;
      sel_vld = region_ok[ent[rsv_idx].region];
      sel_urg = 1'b1;
    end else begin
      sel_idx = ok_idx;
      sel_vld = ok_vld;
      sel_urg = 1'b0;
    end
  end
endmodule

// File: rtl/rd_starve_sched.sv
module rd_starve_sched
  import rss_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int LAT_W     = 10,
  parameter int AVG_INIT  = 32,
  parameter int THR_NUM   = 6,
  parameter int THR_DEN   = 5,
  parameter int EMA_SHIFT = 3,
  localparam int ID_W     = RSS_ID_W,
  localparam int REGION_W = RSS_REGION_W,
  localparam int NREG     = 1 << REGION_W,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int AVG_W    = LAT_W + EMA_SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enq_valid,
  output logic                enq_ready,
  input  logic [ID_W-1:0]     enq_id,
  input  logic [REGION_W-1:0] enq_region,
  input  logic [NREG-1:0]     region_ok,
  output logic                iss_valid,
  input  logic                iss_ready,
  output logic [ID_W-1:0]     iss_id,
  output logic [REGION_W-1:0] iss_region,
  output logic                iss_urgent,
  output logic                rsv_valid,
  output logic [REGION_W-1:0] rsv_region,
  input  logic                cpl_valid,
  input  logic [LAT_W-1:0]    cpl_latency
);
  rss_entry_t       ent [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [AVG_W-1:0] avg_fx;
  logic             sel_vld, sel_urg, rsv_vld;
  logic [IDX_W-1:0] sel_idx, rsv_idx;
  logic             enq_fire, iss_fire;

  assign enq_ready = (cnt != CNT_W'(DEPTH));
  assign enq_fire  = enq_valid && enq_ready;
  assign iss_fire  = sel_vld && iss_ready;

  rss_lat_avg #(.LAT_W(LAT_W), .EMA_SHIFT(EMA_SHIFT), .AVG_INIT(AVG_INIT)) u_avg (
    .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid),
    .cpl_latency(cpl_latency), .avg_fx(avg_fx)
  );

  rss_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .enq_fire(enq_fire), .enq_id(enq_id), .enq_region(enq_region),
    .rm_fire(iss_fire), .rm_idx(sel_idx),
    .ent(ent), .cnt(cnt)
  );

  rss_pick #(
    .DEPTH(DEPTH), .AVG_W(AVG_W), .THR_NUM(THR_NUM),
    .THR_DEN(THR_DEN), .EMA_SHIFT(EMA_SHIFT)
  ) u_pick (
    .ent(ent), .avg_fx(avg_fx), .region_ok(region_ok),
    .sel_vld(sel_vld), .sel_idx(sel_idx), .sel_urg(sel_urg),
    .rsv_vld(rsv_vld), .rsv_idx(rsv_idx)
  );

  assign iss_valid  = sel_vld;
  assign iss_id     = ent[sel_idx].id;
  assign iss_region = ent[sel_idx].region;
  assign iss_urgent = sel_vld && sel_urg;
  assign rsv_valid  = rsv_vld;
  assign rsv_region = ent[rsv_idx].region;
endmodule

// File: rtl/rss_chk.sv
module rss_chk #(
  parameter int REGION_W = 3,
  parameter int NREG     = 8,
  parameter int AVG_W    = 13
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enq_ready,
  input logic                iss_valid,
  input logic                iss_ready,
  input logic [REGION_W-1:0] iss_region,
  input logic                iss_urgent,
  input logic                rsv_valid,
  input logic [REGION_W-1:0] rsv_region,
  input logic [NREG-1:0]     region_ok,
  input logic                cpl_valid,
  input logic [AVG_W-1:0]    avg_fx
);
  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enq_ready && !(iss_valid && iss_ready)) |=> !enq_ready);

  // R3
  admitted_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> region_ok[iss_region]);

  // R8
  urgent_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_valid && iss_valid) |-> (iss_urgent && (iss_region == rsv_region)));

  // R9
  urgent_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_valid && !region_ok[rsv_region]) |-> !iss_valid);

  // R7
  avg_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpl_valid |=> $stable(avg_fx));
endmodule

bind rd_starve_sched rss_chk #(.REGION_W(REGION_W), .NREG(NREG), .AVG_W(AVG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enq_ready(enq_ready), .iss_valid(iss_valid),
  .iss_ready(iss_ready), .iss_region(iss_region), .iss_urgent(iss_urgent),
  .rsv_valid(rsv_valid), .rsv_region(rsv_region), .region_ok(region_ok),
  .cpl_valid(cpl_valid), .avg_fx(avg_fx)
);

// File: tb/rd_starve_sched_tb.sv
`timescale 1ns/1ps
module rd_starve_sched_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enq_valid = 1'b0, iss_ready = 1'b0, cpl_valid = 1'b0;
  logic [3:0] enq_id = '0;
  logic [2:0] enq_region = '0;
  logic [7:0] region_ok = '0;
  logic [9:0] cpl_latency = '0;
  logic       enq_ready, iss_valid, iss_urgent, rsv_valid;
  logic [3:0] iss_id;
  logic [2:0] iss_region, rsv_region;

  always #5 clk = ~clk;

  rd_starve_sched u_dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_id(enq_id), .enq_region(enq_region), .region_ok(region_ok),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_id(iss_id),
    .iss_region(iss_region), .iss_urgent(iss_urgent), .rsv_valid(rsv_valid),
    .rsv_region(rsv_region), .cpl_valid(cpl_valid), .cpl_latency(cpl_latency)
  );

  typedef struct { int id; int region; int age; } req_t;
  req_t  mq[$];
  int    avg_fx = 32 * 8;
  int    n_chk = 0, n_bad = 0, next_id = 0;
  bit    done = 1'b0;
  string ctx = "R1";

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", req, ctx, $time, act, exp);
    end
  endtask

  task automatic cyc(bit ev, int rg, logic [7:0] ok, bit rdy, bit cv, int lat);
    int  urg_k, pick, e_rdy, e_iss, e_urg;
    bit  efire, ifire;
    @(negedge clk);
    enq_valid = ev; enq_id = 4'(next_id); enq_region = 3'(rg);
    region_ok = ok; iss_ready = rdy; cpl_valid = cv; cpl_latency = 10'(lat);
    #1;
    e_rdy = (mq.size() < 16);
    urg_k = -1; pick = -1;
    foreach (mq[k]) if (urg_k < 0 && mq[k].age * 40 > avg_fx * 6) urg_k = k;
    if (urg_k >= 0) begin
      e_urg = 1;
      if (ok[mq[urg_k].region]) pick = urg_k;
    end else begin
      e_urg = 0;
      foreach (mq[k]) if (pick < 0 && ok[mq[k].region]) pick = k;
    end
    e_iss = (pick >= 0);
    check("R2", enq_ready, e_rdy);
    check(urg_k >= 0 ? "R9" : "R3", iss_valid, e_iss);
    check("R10", rsv_valid, urg_k >= 0);
    if (urg_k >= 0 && rsv_valid) check("R6", rsv_region, mq[urg_k].region);
    if (e_iss && iss_valid) begin
      check("R4", iss_id, mq[pick].id);
      check("R3", iss_region, mq[pick].region);
      check("R8", iss_urgent, e_urg);
    end
    efire = ev && e_rdy;
    ifire = e_iss && rdy;
    @(posedge clk);
    if (ifire) mq.delete(pick);
    foreach (mq[k]) if (mq[k].age < 1023) mq[k].age++;
    if (efire) begin
      mq.push_back('{id: next_id, region: rg, age: 0});
      next_id = (next_id + 1) % 16;
    end
    if (cv) avg_fx = avg_fx - (avg_fx >> 3) + lat;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: reset state seen at the ports
    @(negedge clk); #1;
    check("R1", enq_ready, 1);
    check("R1", iss_valid, 0);
    check("R1", rsv_valid, 0);

    // R2: fill to 16 with nothing admitted, then push against a full queue
    ctx = "R2";
    for (int i = 0; i < 18; i++) cyc(1, i % 8, 8'h00, 1, 0, 0);
    for (int i = 0; i < 30; i++) cyc(1, 1, 8'h00, 0, 0, 0);
    // drain in order while enqueuing, R4
    ctx = "R4";
    for (int i = 0; i < 40; i++) cyc(i % 2, i % 4, 8'hFF, 1, 0, 0);

    // starvation: region 7 kept out while bottom traffic flows, R9 then R8
    ctx = "R9";
    cyc(1, 7, 8'h0F, 1, 0, 0);
    for (int i = 0; i < 70; i++) cyc(1, i % 4, 8'h0F, 1, 0, 0);
    ctx = "R8";
    for (int i = 0; i < 10; i++) cyc(1, i % 4, 8'hFF, 1, 0, 0);
    for (int i = 0; i < 20; i++) cyc(0, 0, 8'hFF, 1, 0, 0);

    // latency average moves the threshold, R7 and R6
    ctx = "R7";
    for (int i = 0; i < 30; i++) cyc(i < 4, 6, 8'h00, 0, 1, 200 + i);
    for (int i = 0; i < 300; i++) cyc(0, 0, 8'h00, 0, i % 50 == 0, 20);
    ctx = "R6";
    for (int i = 0; i < 20; i++) cyc(0, 0, 8'hFF, 1, 0, 0);

    // R5: one entry held past the age limit; wrapping would drop urgency
    ctx = "R5";
    cyc(1, 5, 8'hDF, 1, 0, 0);
    for (int i = 0; i < 1100; i++) cyc(0, 0, 8'hDF, 1, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 8'hFF, 1, 0, 0);

    // random traffic with same-cycle enqueue, issue and completion
    ctx = "mix";
    for (int i = 0; i < 3000; i++)
      cyc($urandom % 2, $urandom % 8, 8'($urandom), ($urandom % 4) != 0,
          ($urandom % 5) == 0, $urandom % 120);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule